// File: doc/BRIEF.md
# Frame correction buffer

This block holds one configuration frame of 41 words of 32 bits (1312 bits) while a scrubbing controller reads it back from the device. If the readback check reports a single wrong bit, the controller asks the buffer to repair that bit. The repair is a read-modify-write on the stored word. The controller then streams the repaired frame out to the rewrite path. The frame is the smallest unit the device can rewrite, so the whole frame always goes back, even when only one bit was wrong.

Three one-cycle commands drive the block: load, correct and unload. Each command finishes with its own done pulse. The correct command carries a 12-bit syndrome. The top bit of the syndrome flags a double error. The low 11 bits give the bit position inside the frame. The buffer is a dual-port memory: the capture side writes through one port, and the correction and unload engine reads and writes through the other. Only one command is handled at a time. A command that arrives while the block is busy is dropped.

Top module: `frame_fix_buf`

## Requirements
- R1: After a load command, the next 41 cycles with `cap_valid` high store `cap_data` in arrival order. `load_done` is high for the one cycle after the 41st word is sampled, and `frame_incomplete` falls in that same cycle.
- R2: Words offered while no load is in progress are not stored. This covers words sent before a load command and words sent after the 41st word. The frame that is later unloaded shows no trace of them.
- R3: `frame_incomplete` is high out of reset. It goes high again when a load command is accepted and stays high until 41 words have arrived. An unload command given while it is high produces no output and no `unload_done`.
- R4: Take a syndrome with bit 11 = 0 and L = syndrome[10:0] in the range 1..1311. This inverts bit L[4:0] of word L>>5 and leaves every other bit unchanged. `correct_done` is high in the third cycle after the command cycle, which is the cycle after the write, and both error flags are low.
- R5: A syndrome with bit 11 = 1 and L != 0 changes nothing. `uncorrectable` goes high and `loc_error` goes low in the cycle after the command, together with `correct_done`.
- R6: A syndrome with L = 0, whatever bit 11 holds, changes nothing. `correct_done` is high in the cycle after the command, and both error flags are low.
- R7: A syndrome with bit 11 = 0 and L >= 1312 changes nothing. `loc_error` goes high and `uncorrectable` goes low in the cycle after the command, together with `correct_done`.
- R8: After an accepted unload command, `out_valid` rises in the second cycle after the command cycle. The block presents the stored words in capture order, moves to the next word after each cycle where `out_valid` and `out_ready` are both high, and holds `out_data` stable while `out_ready` is low.
- R9: `out_last` is high only with the 41st word. `unload_done` is high for the one cycle after that word's handshake, and `out_valid` falls in the same cycle.
- R10: Commands are taken only when no load, correction or unload is in progress. If several arrive in the same cycle, load wins over correct, and correct wins over unload.
- R11: `load_done` and `unload_done` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Readback word valid |
| cap_data | input | 32 | Readback word |
| cmd_load | input | 1 | Start capturing a frame |
| cmd_correct | input | 1 | Repair using `syndrome` |
| cmd_unload | input | 1 | Stream the stored frame out |
| syndrome | input | 12 | Bit 11 = double-error flag; bits 10:0 = bit location |
| load_done | output | 1 | Capture finished (one-cycle pulse) |
| correct_done | output | 1 | Correction finished (one-cycle pulse) |
| unload_done | output | 1 | Stream finished (one-cycle pulse) |
| frame_incomplete | output | 1 | No full frame is held |
| uncorrectable | output | 1 | Last syndrome marked a double error |
| loc_error | output | 1 | Last syndrome pointed past the frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Rewrite path accepts the word |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Output word is the 41st |

## Verification
The assertions watch properties that must hold on every cycle. The two done pulses stay one cycle wide. The end-of-frame marker only appears on a valid word. Output data holds under backpressure. An unload never starts without a complete frame. The two error flags are never high together. What happens to the data needs the bench's own scenarios: where a flipped bit lands at the first word, the last word and across a word boundary, that unload order and content are unchanged by stray or extra readback words, that the refused syndromes change nothing, and how commands are ranked or dropped while the block is busy.

// File: rtl/ffb_pkg.sv
package ffb_pkg;
  typedef enum logic [2:0] {
    CT_IDLE,
    CT_RD,
    CT_WR,
    CT_FETCH,
    CT_SEND
  } ctl_state_t;
endpackage

// File: rtl/ffb_ram.sv
module ffb_ram #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 41,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  input  logic              b_re,
  input  logic              b_we,
  input  logic [AW-1:0]     b_addr,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_q
);
  logic [WORD_W-1:0] mem [DEPTH];

  // storage has no reset; port B read data holds when not enabled
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    if (b_re) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/ffb_loader.sv
module ffb_loader #(
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 41,
  parameter int AW          = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cap_valid,
  input  logic [WORD_W-1:0] cap_data,
  output logic              active,
  output logic              incomplete,
  output logic              done,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  localparam logic [AW-1:0] LAST = AW'(FRAME_WORDS - 1);

  logic          act_q, act_d;
  logic          inc_q, inc_d;
  logic          done_q, done_d;
  logic [AW-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d  = act_q;
    inc_d  = inc_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    wr_en  = act_q && cap_valid;
    if (start) begin
      act_d = 1'b1;
      inc_d = 1'b1;
      cnt_d = '0;
    end else if (wr_en) begin
      if (cnt_q == LAST) begin
        act_d  = 1'b0;
        inc_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      inc_q  <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      inc_q  <= inc_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign active     = act_q;
  assign incomplete = inc_q;
  assign done       = done_q;
  assign wr_addr    = cnt_q;
  assign wr_data    = cap_data;
endmodule

// File: rtl/ffb_ctrl.sv
module ffb_ctrl
  import ffb_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 41,
  parameter int SYN_W       = 12,
  parameter int AW          = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cor,
  input  logic [SYN_W-1:0]  syndrome,
  input  logic              start_ul,
  input  logic              out_ready,
  input  logic [WORD_W-1:0] b_q,
  output logic              idle,
  output logic              b_re,
  output logic              b_we,
  output logic [AW-1:0]     b_addr,
  output logic [WORD_W-1:0] b_wdata,
  output logic              cor_done,
  output logic              unc_flag,
  output logic              loc_flag,
  output logic              ul_done,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  localparam int              LOC_W      = SYN_W - 1;
  localparam int              BW         = $clog2(WORD_W);
  localparam logic [31:0]     FRAME_BITS = 32'(WORD_W * FRAME_WORDS);
  localparam logic [AW-1:0]   LAST       = AW'(FRAME_WORDS - 1);

  ctl_state_t    st_q, st_d;
  logic [AW-1:0] word_q, word_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          cdone_q, cdone_d;
  logic          udone_q, udone_d;
  logic          unc_q, unc_d;
  logic          lerr_q, lerr_d;

  logic [LOC_W-1:0]  loc;
  logic              dbl, loc_zero, loc_oor;
  logic [WORD_W-1:0] flip_mask;

  assign loc      = syndrome[LOC_W-1:0];
  assign dbl      = syndrome[SYN_W-1];
  assign loc_zero = (loc == '0);
  assign loc_oor  = (32'(loc) >= FRAME_BITS);

  for (genvar g = 0; g < WORD_W; g++) begin : g_mask
    assign flip_mask[g] = (bit_q == BW'(g));
  end

  always_comb begin
    st_d    = st_q;
    word_d  = word_q;
    bit_d   = bit_q;
    idx_d   = idx_q;
    cdone_d = 1'b0;
    udone_d = 1'b0;
    unc_d   = unc_q;
    lerr_d  = lerr_q;
    idle      = 1'b0;
    b_re      = 1'b0;
    b_we      = 1'b0;
    b_addr    = '0;
    b_wdata   = b_q ^ flip_mask;
    out_valid = 1'b0;
    out_last  = 1'b0;
    case (st_q)
      CT_IDLE: begin
        idle = 1'b1;
        if (start_cor) begin
          if (dbl && !loc_zero) begin
            unc_d   = 1'b1;
            lerr_d  = 1'b0;
            cdone_d = 1'b1;
          end else if (loc_zero) begin
            unc_d   = 1'b0;
            lerr_d  = 1'b0;
            cdone_d = 1'b1;
          end else if (loc_oor) begin
            unc_d   = 1'b0;
            lerr_d  = 1'b1;
            cdone_d = 1'b1;
          end else begin
            unc_d  = 1'b0;
            lerr_d = 1'b0;
            word_d = AW'(loc >> BW);
            bit_d  = loc[BW-1:0];
            st_d   = CT_RD;
          end
        end else if (start_ul) begin
          idx_d = '0;
          st_d  = CT_FETCH;
        end
      end
      CT_RD: begin
        b_re   = 1'b1;
        b_addr = word_q;
        st_d   = CT_WR;
      end
      CT_WR: begin
        b_we    = 1'b1;
        b_addr  = word_q;
        cdone_d = 1'b1;
        st_d    = CT_IDLE;
      end
      CT_FETCH: begin
        b_re   = 1'b1;
        b_addr = '0;
        st_d   = CT_SEND;
      end
      CT_SEND: begin
        out_valid = 1'b1;
        out_last  = (idx_q == LAST);
        if (out_ready) begin
          if (idx_q == LAST) begin
            udone_d = 1'b1;
            st_d    = CT_IDLE;
          end else begin
            b_re   = 1'b1;
            b_addr = idx_q + AW'(1);
            idx_d  = idx_q + AW'(1);
          end
        end
      end
      default: st_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CT_IDLE;
      word_q  <= '0;
      bit_q   <= '0;
      idx_q   <= '0;
      cdone_q <= 1'b0;
      udone_q <= 1'b0;
      unc_q   <= 1'b0;
      lerr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      word_q  <= word_d;
      bit_q   <= bit_d;
      idx_q   <= idx_d;
      cdone_q <= cdone_d;
      udone_q <= udone_d;
      unc_q   <= unc_d;
      lerr_q  <= lerr_d;
    end
  end

  assign cor_done = cdone_q;
  assign ul_done  = udone_q;
  assign unc_flag = unc_q;
  assign loc_flag = lerr_q;
  assign out_data = b_q;
endmodule

// File: rtl/frame_fix_buf.sv
module frame_fix_buf #(
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 41,
  parameter int SYN_W       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [WORD_W-1:0] cap_data,
  input  logic              cmd_load,
  input  logic              cmd_correct,
  input  logic              cmd_unload,
  input  logic [SYN_W-1:0]  syndrome,
  output logic              load_done,
  output logic              correct_done,
  output logic              unload_done,
  output logic              frame_incomplete,
  output logic              uncorrectable,
  output logic              loc_error,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  localparam int AW = $clog2(FRAME_WORDS);

  logic              ld_active, ctl_idle, blk_idle;
  logic              start_ld, start_cor, start_ul;
  logic              a_we;
  logic [AW-1:0]     a_addr;
  logic [WORD_W-1:0] a_wdata;
  logic              b_re, b_we;
  logic [AW-1:0]     b_addr;
  logic [WORD_W-1:0] b_wdata, b_q;

  // one command at a time; load ranks above correct, correct above unload
  assign blk_idle  = ctl_idle && !ld_active;
  assign start_ld  = blk_idle && cmd_load;
  assign start_cor = blk_idle && !cmd_load && cmd_correct;
  assign start_ul  = blk_idle && !cmd_load && !cmd_correct && cmd_unload
                     && !frame_incomplete;

  ffb_loader #(.WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .AW(AW)) u_ld (
    .clk(clk), .rst_n(rst_n), .start(start_ld),
    .cap_valid(cap_valid), .cap_data(cap_data),
    .active(ld_active), .incomplete(frame_incomplete), .done(load_done),
    .wr_en(a_we), .wr_addr(a_addr), .wr_data(a_wdata)
  );

  ffb_ram #(.WORD_W(WORD_W), .DEPTH(FRAME_WORDS), .AW(AW)) u_ram (
    .clk(clk),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .b_re(b_re), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_q(b_q)
  );

  ffb_ctrl #(.WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .SYN_W(SYN_W), .AW(AW)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .start_cor(start_cor), .syndrome(syndrome), .start_ul(start_ul),
    .out_ready(out_ready), .b_q(b_q), .idle(ctl_idle),
    .b_re(b_re), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .cor_done(correct_done), .unc_flag(uncorrectable), .loc_flag(loc_error),
    .ul_done(unload_done), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last)
  );
endmodule

// File: rtl/ffb_chk.sv
module ffb_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_incomplete,
  input logic              load_done,
  input logic              unload_done,
  input logic              uncorrectable,
  input logic              loc_error,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_last
);
  // R11
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);
  // R11
  unload_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unload_done |=> !unload_done);
  // R9
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R3
  unload_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !frame_incomplete);
  // R1
  load_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !frame_incomplete);
  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(uncorrectable && loc_error));
endmodule

bind frame_fix_buf ffb_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_incomplete(frame_incomplete),
  .load_done(load_done), .unload_done(unload_done),
  .uncorrectable(uncorrectable), .loc_error(loc_error),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last)
);

// File: tb/sim_frame_fix_buf.sv
`timescale 1ns/1ps
module sim_frame_fix_buf;
  localparam int NW = 41;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 1'b0;
  logic [31:0] cap_data = '0;
  logic        cmd_load = 1'b0, cmd_correct = 1'b0, cmd_unload = 1'b0;
  logic [11:0] syndrome = '0;
  logic        out_ready = 1'b1;
  logic        load_done, correct_done, unload_done, frame_incomplete;
  logic        uncorrectable, loc_error, out_valid, out_last;
  logic [31:0] out_data;

  int    errors = 0, checks = 0, cyc = 0, ready_mode = 0;
  bit    chk_en = 1'b0;
  string phase = "reset";

  always #2 clk = ~clk;

  frame_fix_buf u0 (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_data(cap_data),
    .cmd_load(cmd_load), .cmd_correct(cmd_correct), .cmd_unload(cmd_unload),
    .syndrome(syndrome), .load_done(load_done), .correct_done(correct_done),
    .unload_done(unload_done), .frame_incomplete(frame_incomplete),
    .uncorrectable(uncorrectable), .loc_error(loc_error),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  // behavioural reference model
  logic [31:0] m_mem [NW];
  bit m_ld_act, m_inc, m_ld_done, m_cc_done, m_ul_done, m_unc, m_lerr;
  bit m_ul_act, m_ul_send;
  int m_cnt, m_cc, m_cw, m_cb, m_idx;

  always @(posedge clk) begin
    bit idle_now;
    int loc;
    cyc++;
    if (!rst_n) begin
      m_ld_act = 0; m_inc = 1; m_ld_done = 0; m_cc_done = 0; m_ul_done = 0;
      m_unc = 0; m_lerr = 0; m_ul_act = 0; m_ul_send = 0;
      m_cnt = 0; m_cc = 0; m_idx = 0;
    end else begin
      idle_now = !m_ld_act && (m_cc == 0) && !m_ul_act;
      m_ld_done = 0; m_cc_done = 0; m_ul_done = 0;
      if (m_ld_act && cap_valid) begin
        m_mem[m_cnt] = cap_data;
        m_cnt++;
        if (m_cnt == NW) begin m_ld_act = 0; m_inc = 0; m_ld_done = 1; end
      end
      if (m_cc == 2) m_cc = 1;
      else if (m_cc == 1) begin
        m_mem[m_cw][m_cb] = ~m_mem[m_cw][m_cb];
        m_cc = 0; m_cc_done = 1;
      end
      if (m_ul_act) begin
        if (!m_ul_send) m_ul_send = 1;
        else if (out_ready) begin
          if (m_idx == NW - 1) begin m_ul_act = 0; m_ul_send = 0; m_ul_done = 1; end
          else m_idx++;
        end
      end
      if (idle_now) begin
        loc = int'(syndrome[10:0]);
        if (cmd_load) begin
          m_ld_act = 1; m_cnt = 0; m_inc = 1;
        end else if (cmd_correct) begin
          if (syndrome[11] && loc != 0) begin m_unc = 1; m_lerr = 0; m_cc_done = 1; end
          else if (loc == 0) begin m_unc = 0; m_lerr = 0; m_cc_done = 1; end
          else if (loc >= 32 * NW) begin m_unc = 0; m_lerr = 1; m_cc_done = 1; end
          else begin m_unc = 0; m_lerr = 0; m_cw = loc / 32; m_cb = loc % 32; m_cc = 2; end
        end else if (cmd_unload && !m_inc) begin
          m_ul_act = 1; m_ul_send = 0; m_idx = 0;
        end
      end
      chk_en = 1'b1;
    end
    if (cyc == 1) chk_en = 1'b1;
  end

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t: actual %h expected %h", req, phase, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (chk_en) begin
      bit ev;
      ev = m_ul_act && m_ul_send;
      cmp("R1 load_done", 32'(load_done), 32'(m_ld_done));
      cmp("R3 frame_incomplete", 32'(frame_incomplete), 32'(m_inc));
      cmp("R4 correct_done", 32'(correct_done), 32'(m_cc_done));
      cmp("R5 uncorrectable", 32'(uncorrectable), 32'(m_unc));
      cmp("R7 loc_error", 32'(loc_error), 32'(m_lerr));
      cmp("R8 out_valid", 32'(out_valid), 32'(ev));
      cmp("R9 out_last", 32'(out_last), 32'(ev && m_idx == NW - 1));
      cmp("R9 unload_done", 32'(unload_done), 32'(m_ul_done));
      if (ev) cmp("R8 out_data", out_data, m_mem[m_idx]);
    end
  end

  always @(negedge clk) begin
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = cyc[0];
      default: out_ready = (cyc % 3 == 0);
    endcase
  end

  function automatic logic [31:0] wval(input int seed, input int i);
    return 32'(seed) ^ (32'h9E3779B9 * 32'(i + 1));
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit ld, input bit co, input bit ul, input logic [11:0] syn);
    @(negedge clk);
    cmd_load = ld; cmd_correct = co; cmd_unload = ul; syndrome = syn;
    @(negedge clk);
    cmd_load = 0; cmd_correct = 0; cmd_unload = 0; syndrome = '0;
  endtask

  task automatic feed(input int n, input int seed, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cap_valid = 1; cap_data = wval(seed, i);
      if (gaps && (i % 3 == 0)) begin
        @(negedge clk);
        cap_valid = 0;
      end
    end
    @(negedge clk);
    cap_valid = 0;
  endtask

  task automatic fix(input logic [11:0] syn);
    pulse(0, 1, 0, syn);
    idle(4);
  endtask

  task automatic unload(input int mode);
    ready_mode = mode;
    pulse(0, 0, 1, '0);
    idle(150);
    ready_mode = 0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    phase = "reset state"; idle(3);
    phase = "R3 unload with no frame"; pulse(0, 0, 1, '0); idle(6);
    phase = "R2 words before load"; feed(5, 32'h1111, 0); idle(2);
    phase = "R1 load with gaps, R2 extra words";
    pulse(1, 0, 0, '0);
    feed(NW + 4, 32'h5A5A, 1); idle(3);
    phase = "R8 unload ready high"; unload(0);
    phase = "R4 flip word0 bit5"; fix(12'd5);
    phase = "R4 flip last bit"; fix(12'd1311);
    phase = "R4 flip word1 bit5"; fix(12'd37);
    phase = "R8 unload ready toggling"; unload(1);
    phase = "R5 double error"; fix(12'h800 | 12'd100);
    phase = "R6 zero syndrome"; fix(12'h000);
    phase = "R6 parity-only syndrome"; fix(12'h800);
    phase = "R7 location 1312"; fix(12'd1312);
    phase = "R7 location 2047"; fix(12'h7FF);
    phase = "R9 unload slow ready"; unload(2);
    phase = "R10 correct during unload";
    ready_mode = 1;
    pulse(0, 0, 1, '0);
    idle(5);
    pulse(0, 1, 0, 12'd40);
    pulse(1, 0, 0, '0);
    idle(100);
    ready_mode = 0;
    phase = "R10 load beats correct";
    pulse(1, 1, 1, 12'd9);
    phase = "R3 short load blocks unload";
    feed(10, 32'h7777, 0);
    pulse(0, 0, 1, '0); idle(6);
    phase = "R1 finish load";
    feed(NW - 10, 32'h7777, 0); idle(3);
    phase = "R11 back to back unloads"; unload(0); unload(0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule